// File: doc/BRIEF.md
# Serial Host Port for a Nibble-Wide Display Memory

This block is the slave end of a three-wire host link into a 256-location, 4-bit display memory. The host lowers an active-low select, clocks bits in on the rising edges of a write strobe and clocks memory bits out on the rising edges of a read strobe. All of this happens over one shared data line. Every pin is sampled in the block's own system clock through a two-flop synchroniser, and the strobe edges are then found in that clock domain. The display memory is held inside the block.

Each frame opens with a 3-bit mode ID. After the ID the frame carries one of the following:
- an 8-bit start address followed by a stream of nibbles to read;
- an 8-bit start address followed by a stream of nibbles to write;
- an 8-bit start address followed by read-then-write nibble pairs;
- a run of back-to-back 9-bit configuration commands.

The commands drive level outputs for system enable, display enable, timer, watchdog, interrupt, tone and time-base rate. Two of them produce one-cycle clear pulses. A separate output enable tells the pad logic when the block owns the data line.

Top module: `lcd_ram_serial_port`

## Requirements
- R1: After reset every control output is 0 except rate_sel, which is 3'b111. test_mode is 0, sdata_oe is 0 and every memory location reads 4'h0.
- R2: The first three bits after cs_n falls form the mode ID, sent first bit first: 110 reads, 101 writes (or read-modify-writes), 100 enters command mode. With any other ID the rest of the frame is ignored.
- R3: Bits are captured on each rising edge of wr_n. The 8-bit address is sent MSB first. Each data nibble is sent bit 0 first.
- R4: In a 101 frame, each complete nibble written by the host is stored at the current address, and the address then advances by one. Following nibbles need no new ID or address, and the address wraps from 255 to 0.
- R5: In a 110 frame, each rising edge of rd_n drives the next bit of the nibble at the current address onto sdata_o, bit 0 first. After four bits the address advances by one, and it wraps from 255 to 0.
- R6: In a 101 frame, rd_n edges shift out the nibble at the current address without moving the address. The next complete written nibble goes to that same address, and only then does the address advance.
- R7: Raising cs_n aborts any transfer. A partly sent nibble is discarded, sdata_oe drops, and the next frame must start with a new ID.
- R8: Commands are 9 bits sent MSB first. The upper 8 bits are decoded and the last bit is ignored. Further commands follow back to back in the same frame. The codes are: 8'h00/8'h01 system off/on, 8'h02/8'h03 display off/on, 8'h04/8'h06 timer off/on, 8'h05/8'h07 watchdog off/on, 8'h08 tone off, 8'hE0 test mode, 8'hE3 normal mode.
- R9: 8'b010x_xxxx turns the tone on with tone_4k=1. 8'b0110_xxxx turns the tone on with tone_4k=0. 8'b100x_0xxx clears irq_on and 8'b100x_1xxx sets it. 8'b101x_0abc loads rate_sel with abc.
- R10: Code 8'h0D gives a one-cycle pulse on timer_clr, and code 8'h0F gives a one-cycle pulse on wdt_clr. No other code pulses either output.
- R11: A command code not listed in R8 to R10 changes no output.
- R12: sdata_oe rises only on a read-strobe edge that shifts out a data bit. It stays high until the next write-strobe edge or until cs_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select (asynchronous) |
| wr_n | input | 1 | Write strobe; bits are taken on its rising edge |
| rd_n | input | 1 | Read strobe; bits are driven on its rising edge |
| sdata_i | input | 1 | Data line as seen at the pad input |
| sdata_o | output | 1 | Read data bit for the pad driver |
| sdata_oe | output | 1 | Pad driver enable for read data |
| sys_on | output | 1 | System enable level |
| lcd_on | output | 1 | Display enable level |
| timer_on | output | 1 | Time-base output enable |
| wdt_on | output | 1 | Watchdog flag enable |
| irq_on | output | 1 | Interrupt output enable |
| tone_on | output | 1 | Tone output enable |
| tone_4k | output | 1 | Tone pitch select: 1 high, 0 low |
| rate_sel | output | 3 | Time-base rate select |
| test_mode | output | 1 | Test mode level |
| timer_clr | output | 1 | One-cycle time-base clear pulse |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse |

## Verification
The bench goes after the address wrap at 255, for both writes and reads. A design that saturated or dropped the carry would return the wrong location after 0xFF. It also targets read-modify-write pairs, where advancing the address on the read half would put the new nibble at the next location. Frames cut short by cs_n mid-ID and mid-nibble are covered: a design that kept partial state would write garbage or decode a stale ID. The bench also sends invalid IDs and unlisted or wildcard command codes. A decoder that compared too few or too many bits would then change an output that must hold, or miss one of the clear pulses.

// File: rtl/lcdsi_pkg.sv
package lcdsi_pkg;

   localparam int CODE_BITS = 8;
   localparam int RATE_BITS = 3;

   localparam logic [2:0] ID_READ  = 3'b110;
   localparam logic [2:0] ID_WRITE = 3'b101;
   localparam logic [2:0] ID_CONF  = 3'b100;

   typedef enum logic [2:0] {
      ST_ID,
      ST_ADDR,
      ST_DATA,
      ST_CMD,
      ST_SINK
   } frame_st_e;

   typedef struct packed {
      logic                 sys_on;
      logic                 lcd_on;
      logic                 timer_on;
      logic                 wdt_on;
      logic                 irq_on;
      logic                 tone_on;
      logic                 tone_4k;
      logic [RATE_BITS-1:0] rate;
      logic                 test;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{sys_on: 1'b0, lcd_on: 1'b0, timer_on: 1'b0,
                                  wdt_on: 1'b0, irq_on: 1'b0, tone_on: 1'b0,
                                  tone_4k: 1'b0, rate: '1, test: 1'b0};

endpackage

// File: rtl/lcdsi_sync.sv
module lcdsi_sync #(
   parameter int         N       = 4,
   parameter int         STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] level_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lcdsi_sync: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_n
      $error("lcdsi_sync: N must be positive");
   end

   logic [STAGES-1:0][N-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= async_i;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign level_o = stg[STAGES-1];

endmodule

// File: rtl/lcdsi_ram.sv
module lcdsi_ram #(
   parameter int AW    = 8,
   parameter int DW    = 4,
   parameter bit CLEAR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("lcdsi_ram: AW out of range");
   end

   logic [DW-1:0] mem [DEPTH];

   if (CLEAR) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[addr] <= wdata;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (we) mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/lcdsi_cmd.sv
module lcdsi_cmd
   import lcdsi_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid,
   input  logic [CODE_BITS-1:0] code,
   output ctl_t                 ctl,
   output logic                 timer_clr,
   output logic                 wdt_clr
);

   ctl_t ctl_q, ctl_d;
   logic tclr_d, wclr_d;
   logic tclr_q, wclr_q;

   always_comb begin
      ctl_d  = ctl_q;
      tclr_d = 1'b0;
      wclr_d = 1'b0;
      if (valid) begin
         casez (code)
            8'b0000_0000: ctl_d.sys_on   = 1'b0;
            8'b0000_0001: ctl_d.sys_on   = 1'b1;
            8'b0000_0010: ctl_d.lcd_on   = 1'b0;
            8'b0000_0011: ctl_d.lcd_on   = 1'b1;
            8'b0000_0100: ctl_d.timer_on = 1'b0;
            8'b0000_0110: ctl_d.timer_on = 1'b1;
            8'b0000_0101: ctl_d.wdt_on   = 1'b0;
            8'b0000_0111: ctl_d.wdt_on   = 1'b1;
            8'b0000_1000: ctl_d.tone_on  = 1'b0;
            8'b0000_1101: tclr_d         = 1'b1;
            8'b0000_1111: wclr_d         = 1'b1;
            8'b010?_????: begin
               ctl_d.tone_on = 1'b1;
               ctl_d.tone_4k = 1'b1;
            end
            8'b0110_????: begin
               ctl_d.tone_on = 1'b1;
               ctl_d.tone_4k = 1'b0;
            end
            8'b100?_0???: ctl_d.irq_on   = 1'b0;
            8'b100?_1???: ctl_d.irq_on   = 1'b1;
            8'b101?_0???: ctl_d.rate     = code[RATE_BITS-1:0];
            8'b1110_0000: ctl_d.test     = 1'b1;
            8'b1110_0011: ctl_d.test     = 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= CTL_RESET;
         tclr_q <= 1'b0;
         wclr_q <= 1'b0;
      end else begin
         ctl_q  <= ctl_d;
         tclr_q <= tclr_d;
         wclr_q <= wclr_d;
      end
   end

   assign ctl       = ctl_q;
   assign timer_clr = tclr_q;
   assign wdt_clr   = wclr_q;

endmodule

// File: rtl/lcd_ram_serial_port.sv
module lcd_ram_serial_port
   import lcdsi_pkg::*;
#(
   parameter int ADDR_W          = 8,
   parameter int DATA_W          = 4,
   parameter int CMD_W           = 9,
   parameter int ID_W            = 3,
   parameter int SYNC_STAGES     = 2,
   parameter bit RAM_RESET_CLEAR = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 wr_n,
   input  logic                 rd_n,
   input  logic                 sdata_i,
   output logic                 sdata_o,
   output logic                 sdata_oe,
   output logic                 sys_on,
   output logic                 lcd_on,
   output logic                 timer_on,
   output logic                 wdt_on,
   output logic                 irq_on,
   output logic                 tone_on,
   output logic                 tone_4k,
   output logic [RATE_BITS-1:0] rate_sel,
   output logic                 test_mode,
   output logic                 timer_clr,
   output logic                 wdt_clr
);

   localparam int DBIT_W  = $clog2(DATA_W);
   localparam int CNT_TOP = (ADDR_W > CMD_W) ? ADDR_W : CMD_W;
   localparam int CNT_W   = $clog2(CNT_TOP);
   localparam int CODE_W  = CMD_W - 1;

   localparam logic [CNT_W-1:0]  ID_LAST   = CNT_W'(ID_W - 1);
   localparam logic [CNT_W-1:0]  ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0]  CMD_LAST  = CNT_W'(CMD_W - 1);
   localparam logic [DBIT_W-1:0] NIB_LAST  = DBIT_W'(DATA_W - 1);

   if (DATA_W < 2 || (1 << DBIT_W) != DATA_W) begin : g_bad_dw
      $error("lcd_ram_serial_port: DATA_W must be a power of two >= 2");
   end
   if (CODE_W != CODE_BITS) begin : g_bad_cmd
      $error("lcd_ram_serial_port: CMD_W must equal decoded code width + 1");
   end
   if (ID_W != 3) begin : g_bad_id
      $error("lcd_ram_serial_port: ID_W must be 3");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("lcd_ram_serial_port: ADDR_W too small");
   end

   // ---------------- pin synchronisation and strobe edges ----------------
   logic [3:0] lvl;
   logic       cs_hi, wr_lvl, rd_lvl, din;
   logic       wr_prev, rd_prev;
   logic       wr_rise, rd_rise;

   lcdsi_sync #(
      .N       (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1111)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sdata_i, rd_n, wr_n, cs_n}),
      .level_o (lvl)
   );

   assign cs_hi  = lvl[0];
   assign wr_lvl = lvl[1];
   assign rd_lvl = lvl[2];
   assign din    = lvl[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev <= 1'b1;
         rd_prev <= 1'b1;
      end else begin
         wr_prev <= wr_lvl;
         rd_prev <= rd_lvl;
      end
   end

   assign wr_rise = wr_lvl & ~wr_prev;
   assign rd_rise = rd_lvl & ~rd_prev;

   // ---------------- frame sequencer ----------------
   frame_st_e          st;
   logic [CNT_W-1:0]   cnt;
   logic [ID_W-1:0]    id_sh;
   logic [ID_W-1:0]    id_full;
   logic [ADDR_W-1:0]  addr_q;
   logic [CODE_W-1:0]  cmd_sh;
   logic [DATA_W-1:0]  wbuf;
   logic [DBIT_W-1:0]  wbit;
   logic [DBIT_W-1:0]  rbit;
   logic               rd_mode;
   logic               dout_q;
   logic               oe_q;

   logic [DATA_W-1:0]  ram_rdata;
   logic [DATA_W-1:0]  ram_wdata;
   logic               ram_we;
   logic               cmd_valid;
   logic               wr_live;

   assign id_full = {id_sh[ID_W-2:0], din};
   assign wr_live = wr_rise & ~cs_hi;

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         ram_wdata[i] = (DBIT_W'(i) == wbit) ? din : wbuf[i];
      end
   end

   assign ram_we    = wr_live && (st == ST_DATA) && !rd_mode && (wbit == NIB_LAST);
   assign cmd_valid = wr_live && (st == ST_CMD) && (cnt == CMD_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_ID;
         cnt     <= '0;
         id_sh   <= '0;
         addr_q  <= '0;
         cmd_sh  <= '0;
         wbuf    <= '0;
         wbit    <= '0;
         rbit    <= '0;
         rd_mode <= 1'b0;
         dout_q  <= 1'b1;
         oe_q    <= 1'b0;
      end else if (cs_hi) begin
         st   <= ST_ID;
         cnt  <= '0;
         wbit <= '0;
         rbit <= '0;
         oe_q <= 1'b0;
      end else if (wr_rise) begin
         oe_q <= 1'b0;
         unique case (st)
            ST_ID: begin
               id_sh <= id_full;
               if (cnt == ID_LAST) begin
                  cnt <= '0;
                  if (id_full == ID_READ) begin
                     st      <= ST_ADDR;
                     rd_mode <= 1'b1;
                  end else if (id_full == ID_WRITE) begin
                     st      <= ST_ADDR;
                     rd_mode <= 1'b0;
                  end else if (id_full == ID_CONF) begin
                     st <= ST_CMD;
                  end else begin
                     st <= ST_SINK;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ADDR: begin
               addr_q <= {addr_q[ADDR_W-2:0], din};
               if (cnt == ADDR_LAST) begin
                  cnt  <= '0;
                  st   <= ST_DATA;
                  wbit <= '0;
                  rbit <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (!rd_mode) begin
                  wbuf[wbit] <= din;
                  if (wbit == NIB_LAST) begin
                     wbit   <= '0;
                     rbit   <= '0;
                     addr_q <= addr_q + 1'b1;
                  end else begin
                     wbit <= wbit + 1'b1;
                  end
               end
            end
            ST_CMD: begin
               cmd_sh <= {cmd_sh[CODE_W-2:0], din};
               if (cnt == CMD_LAST) cnt <= '0;
               else                 cnt <= cnt + 1'b1;
            end
            default: ;
         endcase
      end else if (rd_rise && st == ST_DATA) begin
         dout_q <= ram_rdata[rbit];
         oe_q   <= 1'b1;
         if (rbit == NIB_LAST) begin
            rbit <= '0;
            if (rd_mode) addr_q <= addr_q + 1'b1;
         end else begin
            rbit <= rbit + 1'b1;
         end
      end
   end

   // ---------------- display memory ----------------
   lcdsi_ram #(
      .AW    (ADDR_W),
      .DW    (DATA_W),
      .CLEAR (RAM_RESET_CLEAR)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ram_we),
      .addr  (addr_q),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   // ---------------- command decoder ----------------
   ctl_t ctl;

   lcdsi_cmd u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (cmd_valid),
      .code      (cmd_sh),
      .ctl       (ctl),
      .timer_clr (timer_clr),
      .wdt_clr   (wdt_clr)
   );

   assign sdata_o   = dout_q;
   assign sdata_oe  = oe_q;
   assign sys_on    = ctl.sys_on;
   assign lcd_on    = ctl.lcd_on;
   assign timer_on  = ctl.timer_on;
   assign wdt_on    = ctl.wdt_on;
   assign irq_on    = ctl.irq_on;
   assign tone_on   = ctl.tone_on;
   assign tone_4k   = ctl.tone_4k;
   assign rate_sel  = ctl.rate;
   assign test_mode = ctl.test;

endmodule

// File: rtl/lcd_ram_serial_port_chk.sv
module lcd_ram_serial_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_hi,
   input logic       rd_rise,
   input logic       cmd_valid,
   input logic       sdata_oe,
   input logic       sys_on,
   input logic       lcd_on,
   input logic [2:0] rate_sel,
   input logic       timer_clr,
   input logic       wdt_clr
);

   assert_oe_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> !sdata_oe);

   assert_oe_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdata_oe) |-> $past(rd_rise));

   assert_sys_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sys_on) |-> $past(cmd_valid));

   assert_lcd_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lcd_on) |-> $past(cmd_valid));

   assert_rate_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rate_sel) |-> $past(cmd_valid));

   assert_tclr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timer_clr |=> !timer_clr);

   assert_wclr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |=> !wdt_clr);

   assert_clr_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_clr || wdt_clr) |-> $past(cmd_valid));

endmodule

bind lcd_ram_serial_port lcd_ram_serial_port_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_hi     (cs_hi),
   .rd_rise   (rd_rise),
   .cmd_valid (cmd_valid),
   .sdata_oe  (sdata_oe),
   .sys_on    (sys_on),
   .lcd_on    (lcd_on),
   .rate_sel  (rate_sel),
   .timer_clr (timer_clr),
   .wdt_clr   (wdt_clr)
);

// File: tb/lcd_ram_serial_port_tb.sv
module lcd_ram_serial_port_tb;

   typedef struct packed {
      logic       sys, lcd, tmr, wdt, irq, tone, hi;
      logic [2:0] rate;
      logic       test;
   } mctl_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, bus_d = 1'b1;
   logic sdata_o, sdata_oe;
   logic sys_on, lcd_on, timer_on, wdt_on, irq_on, tone_on, tone_4k, test_mode;
   logic [2:0] rate_sel;
   logic timer_clr, wdt_clr;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   int seen_tclr = 0, seen_wclr = 0, exp_tclr = 0, exp_wclr = 0;
   logic [3:0] mdl [256];
   mctl_t m;

   always #4 clk = ~clk;

   lcd_ram_serial_port u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .sdata_i(bus_d), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
      .sys_on(sys_on), .lcd_on(lcd_on), .timer_on(timer_on), .wdt_on(wdt_on),
      .irq_on(irq_on), .tone_on(tone_on), .tone_4k(tone_4k), .rate_sel(rate_sel),
      .test_mode(test_mode), .timer_clr(timer_clr), .wdt_clr(wdt_clr)
   );

   always @(posedge clk) begin
      if (timer_clr) seen_tclr++;
      if (wdt_clr)   seen_wclr++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_bad++;
         $display("FAIL watchdog (all R) cycles=%0d expected=<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
         $finish;
      end
   end

   function automatic mctl_t apply_cmd(mctl_t c, logic [7:0] k);
      mctl_t n = c;
      if      (k == 8'h00) n.sys = 1'b0;
      else if (k == 8'h01) n.sys = 1'b1;
      else if (k == 8'h02) n.lcd = 1'b0;
      else if (k == 8'h03) n.lcd = 1'b1;
      else if (k == 8'h04) n.tmr = 1'b0;
      else if (k == 8'h06) n.tmr = 1'b1;
      else if (k == 8'h05) n.wdt = 1'b0;
      else if (k == 8'h07) n.wdt = 1'b1;
      else if (k == 8'h08) n.tone = 1'b0;
      else if (k[7:5] == 3'b010) begin n.tone = 1'b1; n.hi = 1'b1; end
      else if (k[7:4] == 4'b0110) begin n.tone = 1'b1; n.hi = 1'b0; end
      else if (k[7:5] == 3'b100) n.irq = k[3];
      else if (k[7:5] == 3'b101 && !k[3]) n.rate = k[2:0];
      else if (k == 8'hE0) n.test = 1'b1;
      else if (k == 8'hE3) n.test = 1'b0;
      return n;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_ctl(string req);
      mctl_t a;
      a = '{sys_on, lcd_on, timer_on, wdt_on, irq_on, tone_on, tone_4k, rate_sel, test_mode};
      chk(req, 32'(a), 32'(m));
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fr_open();  cs_n = 1'b0; tick(4); endtask
   task automatic fr_close(); cs_n = 1'b1; tick(6); endtask

   task automatic put_bit(logic b);
      bus_d = b; tick(2);
      wr_n = 1'b0; tick(4);
      wr_n = 1'b1; tick(5);
   endtask

   task automatic get_bit(output logic b);
      rd_n = 1'b0; tick(4);
      rd_n = 1'b1; tick(5);
      b = sdata_o;
   endtask

   task automatic put_id(logic [2:0] id);
      for (int i = 2; i >= 0; i--) put_bit(id[i]);
   endtask

   task automatic put_addr(logic [7:0] a);   // R3: address MSB first
      for (int i = 7; i >= 0; i--) put_bit(a[i]);
   endtask

   task automatic put_nib(logic [3:0] d);    // R3: data bit 0 first
      for (int i = 0; i < 4; i++) put_bit(d[i]);
   endtask

   task automatic get_nib(output logic [3:0] d);
      for (int i = 0; i < 4; i++) get_bit(d[i]);
   endtask

   task automatic put_cmd(logic [7:0] k);
      for (int i = 7; i >= 0; i--) put_bit(k[i]);
      put_bit(1'($urandom));
      tick(2);
      m = apply_cmd(m, k);
      if (k == 8'h0D) exp_tclr++;
      if (k == 8'h0F) exp_wclr++;
   endtask

   task automatic read_run(logic [7:0] a, int n, string req);
      logic [3:0] d;
      fr_open(); put_id(3'b110); put_addr(a);
      for (int i = 0; i < n; i++) begin
         get_nib(d);
         chk(req, 32'(d), 32'(mdl[8'(a + i)]));
      end
      fr_close();
   endtask

   initial begin
      logic [7:0] a;
      logic [3:0] d, o;
      int n;
      void'($urandom(32'h5EED_0271));
      for (int i = 0; i < 256; i++) mdl[i] = 4'h0;
      m = '{sys: 0, lcd: 0, tmr: 0, wdt: 0, irq: 0, tone: 0, hi: 0, rate: 3'b111, test: 0};

      tick(5); rst_n = 1'b1; tick(3);
      chk_ctl("R1 controls");
      chk("R1 oe", 32'(sdata_oe), 0);
      read_run(8'h37, 2, "R1 ram zero");

      // R4/R5 random write runs and read-back
      for (int t = 0; t < 6; t++) begin
         a = 8'($urandom);
         n = 1 + int'($urandom % 5);
         fr_open(); put_id(3'b101); put_addr(a);
         for (int i = 0; i < n; i++) begin
            d = 4'($urandom);
            put_nib(d);
            mdl[8'(a + i)] = d;
         end
         chk("R12 oe low in write", 32'(sdata_oe), 0);
         fr_close();
         read_run(a, n, "R4 R5 write/read run");
      end

      // R4 R5 wrap at 255
      fr_open(); put_id(3'b101); put_addr(8'hFE);
      put_nib(4'h9); put_nib(4'h6); put_nib(4'hC);
      mdl[8'hFE] = 4'h9; mdl[8'hFF] = 4'h6; mdl[8'h00] = 4'hC;
      fr_close();
      read_run(8'hFF, 2, "R4 R5 wrap");

      // R12 oe while reading
      fr_open(); put_id(3'b110); put_addr(8'h00);
      chk("R12 oe before read", 32'(sdata_oe), 0);
      get_bit(d[0]);
      chk("R12 oe after read bit", 32'(sdata_oe), 1);
      fr_close();
      chk("R12 oe after cs high", 32'(sdata_oe), 0);

      // R6 read-modify-write
      a = 8'h40;
      fr_open(); put_id(3'b101); put_addr(a);
      for (int i = 0; i < 3; i++) begin
         get_nib(o);
         chk("R6 rmw read", 32'(o), 32'(mdl[8'(a + i)]));
         chk("R12 oe during rmw read", 32'(sdata_oe), 1);
         d = ~o ^ 4'(i);
         put_nib(d);
         chk("R12 oe after rmw write", 32'(sdata_oe), 0);
         mdl[8'(a + i)] = d;
      end
      fr_close();
      read_run(a, 4, "R6 rmw result");

      // R7 abort mid nibble
      fr_open(); put_id(3'b101); put_addr(8'h80);
      put_bit(1'b1); put_bit(1'b1);
      fr_close();
      chk("R7 oe after abort", 32'(sdata_oe), 0);
      read_run(8'h80, 1, "R7 partial nibble dropped");
      // R7 abort mid ID then fresh ID
      fr_open(); put_bit(1'b1); fr_close();
      fr_open(); put_id(3'b101); put_addr(8'h81); put_nib(4'hA); fr_close();
      mdl[8'h81] = 4'hA;
      read_run(8'h81, 1, "R7 new frame needs ID");

      // R2 invalid IDs ignore the frame
      fr_open(); put_id(3'b111); put_addr(8'h10); put_nib(4'hF); put_bit(1'b1); fr_close();
      fr_open(); put_id(3'b011); put_addr(8'h10); put_nib(4'h5); fr_close();
      read_run(8'h10, 1, "R2 bad id ignored");
      chk_ctl("R2 bad id no control change");

      // R8 R9 R10 R11 directed commands, back to back
      fr_open(); put_id(3'b100);
      put_cmd(8'h01); chk_ctl("R8 sys on");
      put_cmd(8'h03); chk_ctl("R8 lcd on");
      put_cmd(8'h06); chk_ctl("R8 timer on");
      put_cmd(8'h07); chk_ctl("R8 wdt on");
      put_cmd(8'h5B); chk_ctl("R9 tone 4k");
      put_cmd(8'h6E); chk_ctl("R9 tone 2k");
      put_cmd(8'h98); chk_ctl("R9 irq on");
      put_cmd(8'hB2); chk_ctl("R9 rate 2");
      put_cmd(8'hAA); chk_ctl("R9 rate ignored when bit3 set");
      put_cmd(8'hE0); chk_ctl("R8 test");
      put_cmd(8'h0D); put_cmd(8'h0F);
      put_cmd(8'h09); chk_ctl("R11 unlisted 09");
      put_cmd(8'hF0); chk_ctl("R11 unlisted F0");
      put_cmd(8'hC3); chk_ctl("R11 unlisted C3");
      put_cmd(8'hE3); chk_ctl("R8 normal");
      put_cmd(8'h08); chk_ctl("R8 tone off");
      put_cmd(8'h90); chk_ctl("R9 irq off");
      put_cmd(8'h02); chk_ctl("R8 lcd off");
      fr_close();
      chk("R10 timer_clr pulses", 32'(seen_tclr), 32'(exp_tclr));
      chk("R10 wdt_clr pulses", 32'(seen_wclr), 32'(exp_wclr));

      // random command streams
      for (int f = 0; f < 4; f++) begin
         fr_open(); put_id(3'b100);
         for (int i = 0; i < 12; i++) begin
            put_cmd(8'($urandom));
            chk_ctl("R8 R9 R11 random command");
         end
         fr_close();
      end
      chk("R10 timer_clr count after random", 32'(seen_tclr), 32'(exp_tclr));
      chk("R10 wdt_clr count after random", 32'(seen_wclr), 32'(exp_wclr));

      // R3 memory survives a command frame
      read_run(8'hFE, 3, "R3 memory intact after commands");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule